// File: doc/BRIEF.md
# Shift-and-Add Fractional Constant Multiplier

This block scales an unsigned integer sample by the fixed coefficient 473/1024 (about 0.4619). The coefficient is held as four signed power-of-two digits: +2^-1, -2^-5, -2^-7 and +2^-10. The product is therefore formed only from shifts, additions and subtractions, and no hardware multiplier is used.

The input is not shifted as a bare integer, because that would throw away the small terms. For an input of 3 the four terms would be 1, 0, 0 and 0. The block first places the integer above a field of zero fractional bits, and only then applies the shifts. The registered result is a fixed-point number. Its upper bits are the integer part and its lower bits are the fraction. The output is due one clock after a valid input and carries its own valid flag.

Top module: `csd_const_mult`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `out_result` equals `in_data` × 473. This is the product in a raw fixed-point form with FRAC_W = 10 fractional bits. It is exact for every 10-bit input: no wrap and no deviation.
- R2: `out_valid` is `in_valid` delayed by exactly one clock.
- R3: While `in_valid` is low, `out_result` keeps its previous value.
- R4: A synchronous, active-high `rst` clears `out_result` and `out_valid` to 0 on the next clock. This holds even while `in_valid` is high.
- R5: Bits [19:10] of `out_result` hold the integer part of the product and bits [9:0] hold the fraction in units of 2^-10. For an input of 3, the integer field is 1 and the fraction field is 395.
- R6: Because the coefficient is below one, a valid result never exceeds `in_data` × 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 10 | Unsigned integer operand |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_result | output | 20 | Product: 10 integer bits above 10 fractional bits |

## Verification
Every result and its valid flag are due on the first rising edge after the input is presented, and a reset takes effect on that same edge. The bench drives inputs on the falling edge. It compares each output on the following falling edge, just after the one register stage has updated. During the full sweep, one input is fed per cycle, and each check looks at the sample driven in the cycle before. The hold and reset tests then leave idle or reset cycles in between and sample one falling edge after each of them.

// File: rtl/csd_mult_pkg.sv
package csd_mult_pkg;
  localparam int NUM_TERMS = 4;

  // right-shift amount of each signed digit
  function automatic int term_shift(input int k);
    case (k)
      0:       return 1;
      1:       return 5;
      2:       return 7;
      default: return 10;
    endcase
  endfunction

  // 1 when the digit is -1
  function automatic bit term_neg(input int k);
    return (k == 1) || (k == 2);
  endfunction

  // coefficient expressed in units of 2^-frac_w
  function automatic longint coef_scaled(input int frac_w);
    longint acc;
    acc = 0;
    for (int k = 0; k < NUM_TERMS; k++) begin
      if (term_neg(k)) acc = acc - (longint'(1) << (frac_w - term_shift(k)));
      else             acc = acc + (longint'(1) << (frac_w - term_shift(k)));
    end
    return acc;
  endfunction
endpackage

// File: rtl/csd_term_gen.sv
module csd_term_gen #(
  parameter int IN_W   = 10,
  parameter int FRAC_W = 10,
  parameter int NT     = csd_mult_pkg::NUM_TERMS,
  localparam int W     = IN_W + FRAC_W
) (
  input  logic [IN_W-1:0] a,
  output logic [NT*W-1:0] terms
);
  logic [W-1:0] ext;
  assign ext = {a, {FRAC_W{1'b0}}};

  for (genvar g = 0; g < NT; g++) begin : g_term
    assign terms[g*W +: W] = ext >> csd_mult_pkg::term_shift(g);
  end
endmodule

// File: rtl/csd_sum.sv
module csd_sum #(
  parameter int W     = 20,
  parameter int NT    = csd_mult_pkg::NUM_TERMS,
  localparam int ACC_W = W + 1
) (
  input  logic [NT*W-1:0]  terms,
  output logic [ACC_W-1:0] acc
);
  always_comb begin
    logic [ACC_W-1:0] t;
    acc = '0;
    for (int k = 0; k < NT; k++) begin
      t = {{(ACC_W-W){1'b0}}, terms[k*W +: W]};
      if (csd_mult_pkg::term_neg(k)) acc = acc - t;
      else                           acc = acc + t;
    end
  end
endmodule

// File: rtl/csd_out_stage.sv
module csd_out_stage #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> q_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> !q_valid);
  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
  // R4
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (q == '0) && !q_valid);
endmodule

// File: rtl/csd_const_mult.sv
module csd_const_mult #(
  parameter int IN_W   = 10,
  parameter int FRAC_W = 10,
  localparam int W     = IN_W + FRAC_W,
  localparam int NT    = csd_mult_pkg::NUM_TERMS,
  localparam int ACC_W = W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  output logic            out_valid,
  output logic [W-1:0]    out_result
);
  localparam logic [W-1:0] COEF_NUM = W'(csd_mult_pkg::coef_scaled(FRAC_W));

  logic [NT*W-1:0]  terms;
  logic [ACC_W-1:0] acc;
  logic             sum_wrapped;

  csd_term_gen #(.IN_W(IN_W), .FRAC_W(FRAC_W), .NT(NT)) u_terms (
    .a(in_data), .terms(terms));

  csd_sum #(.W(W), .NT(NT)) u_sum (.terms(terms), .acc(acc));

  assign sum_wrapped = acc[ACC_W-1];

  csd_out_stage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .load(in_valid), .d(acc[W-1:0]),
    .q_valid(out_valid), .q(out_result));

  // R1
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !sum_wrapped);
  // R1
  exact_product_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_result == ({{FRAC_W{1'b0}}, $past(in_data)} * COEF_NUM));
  // R6
  below_input_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_result <= {$past(in_data), {FRAC_W{1'b0}}});
endmodule

// File: tb/csd_const_mult_test.sv
module csd_const_mult_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [9:0] in_data = '0;
  logic       out_valid;
  logic [19:0] out_result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csd_const_mult uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_result(out_result));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // independent model: four shifts of the fraction-extended operand
  function automatic longint model(input int a);
    longint e;
    e = longint'(a) * 1024;
    return (e / 2) - (e / 32) - (e / 128) + (e / 1024);
  endfunction

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b1; in_data = 10'd1023;
    @(negedge clk); @(negedge clk);
    check(out_valid == 1'b0, "R4 reset valid", out_valid, 0);
    check(out_result == 0, "R4 reset result", out_result, 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_fraction();
    in_valid = 1'b1; in_data = 10'd3;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R2 valid after input", out_valid, 1);
    check(out_result[19:10] == 10'd1, "R5 integer field", out_result[19:10], 1);
    check(out_result[9:0] == 10'd395, "R5 fraction field", out_result[9:0], 395);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 valid drops", out_valid, 0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 1024; i++) begin
      longint exp, diff;
      in_valid = 1'b1; in_data = 10'(i);
      @(negedge clk);
      exp = model(i);
      diff = longint'(out_result) - longint'(i) * 473;
      if (diff < 0) diff = -diff;
      check(out_valid == 1'b1, "R2 sweep valid", out_valid, 1);
      check(longint'(out_result) == exp, "R1 sweep product", out_result, exp);
      check(diff <= 4, "R1 within 4 LSB", diff, 0);
      check(longint'(out_result) <= longint'(i) * 1024, "R6 below input", out_result, i * 1024);
    end
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_hold();
    in_valid = 1'b1; in_data = 10'd700;
    @(negedge clk);
    in_valid = 1'b0; in_data = 10'd5;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R3 idle valid", out_valid, 0);
      check(out_result == 20'(700 * 473), "R3 held result", out_result, 700 * 473);
    end
  endtask

  task automatic t_reset_mid();
    in_valid = 1'b1; in_data = 10'd512;
    @(negedge clk);
    check(out_result == 20'(512 * 473), "R1 before reset", out_result, 512 * 473);
    rst = 1'b1; in_data = 10'd1000;
    @(negedge clk);
    check(out_valid == 1'b0, "R4 mid reset valid", out_valid, 0);
    check(out_result == 0, "R4 mid reset result", out_result, 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fraction();
    t_sweep();
    t_hold();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule